// File: doc/BRIEF.md
# PRINCE Block Cipher Engine with Word-Register Access

This block encrypts or decrypts one 64-bit block with the PRINCE lightweight cipher under a 128-bit key. Software reaches it through a small word-register slave with chip-select, write-enable, an 8-bit word address and 32-bit data buses. Software loads the key and the input block as 32-bit words and sets the direction bit. It then writes the start bit, polls the status bit and reads the 64-bit result.

Inside, a controller steps an iterative datapath one cipher round per clock. The sequence is five forward rounds, the middle involution, five inverse rounds and a finishing whitening step. Decryption runs the same datapath with reflected keys. The controller states are IDLE, FWD, MID, BWD and FIN:
- IDLE goes to FWD on an accepted start.
- FWD stays in FWD until its fifth round, then goes to MID.
- MID goes to BWD after one cycle.
- BWD stays in BWD until its fifth round, then goes to FIN.
- FIN returns to IDLE and raises the result-valid flag.

Top module: `prince_mmio_accel`

## Requirements
- R1: After reset, every key, block, configuration and result word reads 0, and the status register at 0x09 reads 0.
- R2: A write (cs=1, we=1) stores the write data in the key words 0x10–0x13 and the block words 0x20–0x21, and those words read back unchanged. The lower address holds the more significant word. Words 0x10–0x11 form the outer key k0 and words 0x12–0x13 form the core key k1. Only bit 0 of a write to the configuration word 0x0A is kept, and only that bit reads back.
- R3: A read (cs=1, we=0) returns the addressed word combinationally in the same cycle, and the write-data bus has no effect on it. The control word 0x08 and unmapped addresses read 0. rdata is 0 when no read is in progress. The result words 0x30–0x31 are read-only, and writes to them are ignored.
- R4: With configuration bit 0 = 0, the result is the PRINCE encryption of the block. For example, an all-zero block under an all-zero key gives 0x818665AA0D02DFDA.
- R5: With configuration bit 0 = 1, the result is the PRINCE decryption of the block. Decrypting a ciphertext under the same key returns the original plaintext.
- R6: Writing 0x08 with bit 0 = 1 starts an operation. Status bit 0 reads 0 from the cycle after that write. Status and the result words change together 12 clock edges after the start edge. A write to 0x08 with bit 0 = 0 starts nothing.
- R7: A start write while an operation is running is ignored, and the running operation keeps its result and its latency.
- R8: While an operation is running, writes to the key, block and configuration words are ignored.
- R9: The result words keep their previous value until the next operation finishes, and they stay readable while the engine is busy.
- R10: Each operation passes through five forward rounds (indices 1–5), one middle step, five inverse rounds (indices 6–10) and one finishing step, in that order, one per clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cs | input | 1 | Chip-select for a register access |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | 8 | Word address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid in the cycle of the read |

## Verification
The embedded assertions check the following on every cycle:
- the controller never accepts a start while busy;
- the phase order and the round-index ranges;
- the fixed 12-edge latency from start to result-valid;
- the key and configuration stay frozen while busy;
- the result register changes only in the finishing step.

Only the bench scenarios can show the following:
- the ciphertexts match published test vectors;
- decryption round-trips;
- read-only words and unmapped addresses read as required;
- writes made during a run leave both the register contents and the result of that run untouched.

// File: rtl/prince_pkg.sv
package prince_pkg;

    localparam int BLK_W    = 64;
    localparam int KEY_W    = 128;
    localparam int NIB_N    = BLK_W / 4;
    localparam int RND_W    = 4;
    localparam int FWD_LAST = 5;
    localparam int BWD_LAST = 10;
    localparam int FIN_RC   = 11;
    localparam int SR_FWD   = 5;   // nibble i <- nibble (5*i mod 16)
    localparam int SR_INV   = 13;  // multiplicative inverse of 5 mod 16
    localparam logic [BLK_W-1:0] ALPHA = 64'hC0AC29B7C97C50DD;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_FWD,
        PH_MID,
        PH_BWD,
        PH_FIN
    } phase_t;

    function automatic logic [BLK_W-1:0] round_const(input logic [RND_W-1:0] idx);
        logic [BLK_W-1:0] rc;
        case (idx)
            4'd1:    rc = 64'h13198A2E03707344;
            4'd2:    rc = 64'hA4093822299F31D0;
            4'd3:    rc = 64'h082EFA98EC4E6C89;
            4'd4:    rc = 64'h452821E638D01377;
            4'd5:    rc = 64'hBE5466CF34E90C6C;
            4'd6:    rc = 64'h7EF84F78FD955CB1;
            4'd7:    rc = 64'h85840851F1AC43AA;
            4'd8:    rc = 64'hC882D32F25323C54;
            4'd9:    rc = 64'h64A51195E0E3610D;
            4'd10:   rc = 64'hD3B5A399CA0C2399;
            4'd11:   rc = 64'hC0AC29B7C97C50DD;
            default: rc = '0;
        endcase
        return rc;
    endfunction

    function automatic logic [3:0] sbox(input logic [3:0] x);
        logic [3:0] y;
        case (x)
            4'h0: y = 4'hB;  4'h1: y = 4'hF;  4'h2: y = 4'h3;  4'h3: y = 4'h2;
            4'h4: y = 4'hA;  4'h5: y = 4'hC;  4'h6: y = 4'h9;  4'h7: y = 4'h1;
            4'h8: y = 4'h6;  4'h9: y = 4'h7;  4'hA: y = 4'h8;  4'hB: y = 4'h0;
            4'hC: y = 4'hE;  4'hD: y = 4'h5;  4'hE: y = 4'hD;  default: y = 4'h4;
        endcase
        return y;
    endfunction

    function automatic logic [3:0] sbox_inv(input logic [3:0] x);
        logic [3:0] y;
        case (x)
            4'h0: y = 4'hB;  4'h1: y = 4'h7;  4'h2: y = 4'h3;  4'h3: y = 4'h2;
            4'h4: y = 4'hF;  4'h5: y = 4'hD;  4'h6: y = 4'h8;  4'h7: y = 4'h9;
            4'h8: y = 4'hA;  4'h9: y = 4'h6;  4'hA: y = 4'h4;  4'hB: y = 4'h0;
            4'hC: y = 4'h5;  4'hD: y = 4'hE;  4'hE: y = 4'hC;  default: y = 4'h1;
        endcase
        return y;
    endfunction

    function automatic logic [BLK_W-1:0] sub_all(input logic [BLK_W-1:0] x, input logic inv);
        logic [BLK_W-1:0] r;
        for (int n = 0; n < NIB_N; n++) begin
            r[4*n +: 4] = inv ? sbox_inv(x[4*n +: 4]) : sbox(x[4*n +: 4]);
        end
        return r;
    endfunction

    // 16-bit diffusion block: each output bit is the XOR of the same bit
    // position in three of the four nibbles; the skipped nibble rotates.
    function automatic logic [15:0] mix16(input logic [15:0] x, input int rot);
        logic [15:0] r;
        logic        acc;
        int          skip;
        r = '0;
        for (int j = 0; j < 4; j++) begin
            for (int p = 0; p < 4; p++) begin
                skip = (p - j - rot + 8) % 4;
                acc  = 1'b0;
                for (int k = 0; k < 4; k++) begin
                    if (k != skip) acc = acc ^ x[15 - 4*k - p];
                end
                r[15 - 4*j - p] = acc;
            end
        end
        return r;
    endfunction

    function automatic logic [BLK_W-1:0] mix_layer(input logic [BLK_W-1:0] x);
        return {mix16(x[63:48], 0), mix16(x[47:32], 1),
                mix16(x[31:16], 1), mix16(x[15:0], 0)};
    endfunction

    function automatic logic [BLK_W-1:0] permute_nib(input logic [BLK_W-1:0] x, input int mult);
        logic [BLK_W-1:0] r;
        int src;
        for (int i = 0; i < NIB_N; i++) begin
            src = (mult * i) % NIB_N;
            r[BLK_W-1 - 4*i -: 4] = x[BLK_W-1 - 4*src -: 4];
        end
        return r;
    endfunction

endpackage

// File: rtl/prince_regs.sv
module prince_regs
    import prince_pkg::*;
#(
    parameter int                ADDR_W    = 8,
    parameter int                DATA_W    = 32,
    parameter logic [ADDR_W-1:0] KEY_BASE  = 8'h10,
    parameter logic [ADDR_W-1:0] BLK_BASE  = 8'h20,
    parameter logic [ADDR_W-1:0] RES_BASE  = 8'h30,
    parameter logic [ADDR_W-1:0] CTRL_ADDR = 8'h08,
    parameter logic [ADDR_W-1:0] STAT_ADDR = 8'h09,
    parameter logic [ADDR_W-1:0] CFG_ADDR  = 8'h0A
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic              busy,
    input  logic              done,
    input  logic [BLK_W-1:0]  result,
    output logic [KEY_W-1:0]  key,
    output logic [BLK_W-1:0]  block,
    output logic              decrypt,
    output logic              start
);

    localparam int KEY_WORDS = KEY_W / DATA_W;
    localparam int BLK_WORDS = BLK_W / DATA_W;

    logic [DATA_W-1:0] key_w [KEY_WORDS];
    logic [DATA_W-1:0] blk_w [BLK_WORDS];
    logic              cfg_q;
    logic              wr_ok;
    logic              rd_en;

    assign wr_ok = cs && we && !busy;
    assign rd_en = cs && !we;
    assign start = wr_ok && (addr == CTRL_ADDR) && wdata[0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < KEY_WORDS; i++) key_w[i] <= '0;
            for (int i = 0; i < BLK_WORDS; i++) blk_w[i] <= '0;
            cfg_q <= 1'b0;
        end else if (wr_ok) begin
            for (int i = 0; i < KEY_WORDS; i++) begin
                if (addr == KEY_BASE + ADDR_W'(i)) key_w[i] <= wdata;
            end
            for (int i = 0; i < BLK_WORDS; i++) begin
                if (addr == BLK_BASE + ADDR_W'(i)) blk_w[i] <= wdata;
            end
            if (addr == CFG_ADDR) cfg_q <= wdata[0];
        end
    end

    // lower word address carries the more significant word
    for (genvar gk = 0; gk < KEY_WORDS; gk++) begin : g_key
        assign key[KEY_W-1 - gk*DATA_W -: DATA_W] = key_w[gk];
    end
    for (genvar gb = 0; gb < BLK_WORDS; gb++) begin : g_blk
        assign block[BLK_W-1 - gb*DATA_W -: DATA_W] = blk_w[gb];
    end
    assign decrypt = cfg_q;

    always_comb begin
        rdata = '0;
        if (rd_en) begin
            for (int i = 0; i < KEY_WORDS; i++) begin
                if (addr == KEY_BASE + ADDR_W'(i)) rdata = key_w[i];
            end
            for (int i = 0; i < BLK_WORDS; i++) begin
                if (addr == BLK_BASE + ADDR_W'(i)) rdata = blk_w[i];
                if (addr == RES_BASE + ADDR_W'(i)) rdata = result[BLK_W-1 - i*DATA_W -: DATA_W];
            end
            if (addr == STAT_ADDR) rdata = {{(DATA_W-1){1'b0}}, done};
            if (addr == CFG_ADDR)  rdata = {{(DATA_W-1){1'b0}}, cfg_q};
        end
    end

    // R8: no key or configuration change lands while the engine runs
    a_r8_key_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        $past(busy) |-> $stable(key));
    a_r8_cfg_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        $past(busy) |-> $stable(cfg_q));
    a_r8_blk_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        $past(busy) |-> $stable(block));

endmodule

// File: rtl/prince_ctrl.sv
module prince_ctrl
    import prince_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    output phase_t           phase,
    output logic [RND_W-1:0] rnd,
    output logic             load,
    output logic             busy,
    output logic             done
);

    localparam int LATENCY = FWD_LAST + 1 + (BWD_LAST - FWD_LAST) + 1;
    localparam int LAT_W   = $clog2(LATENCY + 2);

    phase_t           state_q;
    logic [RND_W-1:0] rnd_q;
    logic             done_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= PH_IDLE;
            rnd_q   <= '0;
            done_q  <= 1'b0;
        end else begin
            unique case (state_q)
                PH_IDLE: begin
                    if (start) begin
                        state_q <= PH_FWD;
                        rnd_q   <= RND_W'(1);
                        done_q  <= 1'b0;
                    end
                end
                PH_FWD: begin
                    rnd_q <= rnd_q + 1'b1;
                    if (rnd_q == RND_W'(FWD_LAST)) state_q <= PH_MID;
                end
                PH_MID: begin
                    state_q <= PH_BWD;
                end
                PH_BWD: begin
                    if (rnd_q == RND_W'(BWD_LAST)) state_q <= PH_FIN;
                    else                           rnd_q   <= rnd_q + 1'b1;
                end
                PH_FIN: begin
                    state_q <= PH_IDLE;
                    rnd_q   <= '0;
                    done_q  <= 1'b1;
                end
                default: state_q <= PH_IDLE;
            endcase
        end
    end

    always_comb begin
        phase = state_q;
        rnd   = rnd_q;
        busy  = (state_q != PH_IDLE);
        load  = (state_q == PH_IDLE) && start;
        done  = done_q;
    end

    // independent cycle counter for the latency check
    logic [LAT_W-1:0] lat_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                     lat_q <= '0;
        else if (load)                  lat_q <= '0;
        else if (state_q != PH_IDLE)    lat_q <= lat_q + 1'b1;
    end

    a_r6_fixed_latency: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_q) |-> lat_q == LAT_W'(LATENCY));
    a_r7_no_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != PH_IDLE) |-> !start);
    a_r10_fwd_range: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PH_FWD) |-> (rnd_q >= RND_W'(1) && rnd_q <= RND_W'(FWD_LAST)));
    a_r10_bwd_range: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PH_BWD) |-> (rnd_q > RND_W'(FWD_LAST) && rnd_q <= RND_W'(BWD_LAST)));
    a_r10_mid_after_fwd: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PH_MID) |-> $past(state_q) == PH_FWD);

endmodule

// File: rtl/prince_datapath.sv
module prince_datapath
    import prince_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  phase_t           phase,
    input  logic [RND_W-1:0] rnd,
    input  logic             load,
    input  logic [KEY_W-1:0] key,
    input  logic [BLK_W-1:0] block,
    input  logic             decrypt,
    output logic [BLK_W-1:0] result
);

    logic [BLK_W-1:0] st_q;
    logic [BLK_W-1:0] res_q;
    logic [BLK_W-1:0] k0, k0_der, k1;
    logic [BLK_W-1:0] k_pre, k_post, k_core;
    logic [BLK_W-1:0] rc;
    logic [BLK_W-1:0] fwd_nx, mid_nx, bwd_nx, fin_val;

    assign k0     = key[KEY_W-1 -: BLK_W];
    assign k1     = key[BLK_W-1:0];
    assign k0_der = {k0[0], k0[BLK_W-1:1]} ^ {{(BLK_W-1){1'b0}}, k0[BLK_W-1]};

    // reflection: decryption swaps the outer keys and offsets the core key
    assign k_pre  = decrypt ? k0_der : k0;
    assign k_post = decrypt ? k0 : k0_der;
    assign k_core = decrypt ? (k1 ^ ALPHA) : k1;

    assign rc      = round_const(rnd);
    assign fwd_nx  = permute_nib(mix_layer(sub_all(st_q, 1'b0)), SR_FWD) ^ rc ^ k_core;
    assign mid_nx  = sub_all(mix_layer(sub_all(st_q, 1'b0)), 1'b1);
    assign bwd_nx  = sub_all(mix_layer(permute_nib(st_q ^ rc ^ k_core, SR_INV)), 1'b1);
    assign fin_val = st_q ^ round_const(RND_W'(FIN_RC)) ^ k_core ^ k_post;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= '0;
            res_q <= '0;
        end else if (load) begin
            st_q <= block ^ k_pre ^ k_core ^ round_const(RND_W'(0));
        end else begin
            unique case (phase)
                PH_FWD:  st_q  <= fwd_nx;
                PH_MID:  st_q  <= mid_nx;
                PH_BWD:  st_q  <= bwd_nx;
                PH_FIN:  res_q <= fin_val;
                default: st_q  <= st_q;
            endcase
        end
    end

    assign result = res_q;

    a_r9_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (phase != PH_FIN) |=> $stable(res_q));
    a_r10_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_IDLE && !load) |=> $stable(st_q));

endmodule

// File: rtl/prince_mmio_accel.sv
module prince_mmio_accel
    import prince_pkg::*;
#(
    parameter int                ADDR_W    = 8,
    parameter int                DATA_W    = 32,
    parameter logic [ADDR_W-1:0] KEY_BASE  = 8'h10,
    parameter logic [ADDR_W-1:0] BLK_BASE  = 8'h20,
    parameter logic [ADDR_W-1:0] RES_BASE  = 8'h30,
    parameter logic [ADDR_W-1:0] CTRL_ADDR = 8'h08,
    parameter logic [ADDR_W-1:0] STAT_ADDR = 8'h09,
    parameter logic [ADDR_W-1:0] CFG_ADDR  = 8'h0A
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);

    phase_t           phase;
    logic [RND_W-1:0] rnd;
    logic             load, busy, done, start, decrypt;
    logic [KEY_W-1:0] key;
    logic [BLK_W-1:0] block, result;

    prince_regs #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W),
        .KEY_BASE(KEY_BASE), .BLK_BASE(BLK_BASE), .RES_BASE(RES_BASE),
        .CTRL_ADDR(CTRL_ADDR), .STAT_ADDR(STAT_ADDR), .CFG_ADDR(CFG_ADDR)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .cs(cs), .we(we), .addr(addr),
        .wdata(wdata), .rdata(rdata), .busy(busy), .done(done),
        .result(result), .key(key), .block(block), .decrypt(decrypt),
        .start(start)
    );

    prince_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start), .phase(phase),
        .rnd(rnd), .load(load), .busy(busy), .done(done)
    );

    prince_datapath u_dp (
        .clk(clk), .rst_n(rst_n), .phase(phase), .rnd(rnd), .load(load),
        .key(key), .block(block), .decrypt(decrypt), .result(result)
    );

endmodule

// File: tb/prince_mmio_accel_test.sv
module prince_mmio_accel_test;

    logic        clk   = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs    = 1'b0;
    logic        we    = 1'b0;
    logic [7:0]  addr  = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;

    always #5 clk = ~clk;

    prince_mmio_accel uut (
        .clk(clk), .rst_n(rst_n), .cs(cs), .we(we),
        .addr(addr), .wdata(wdata), .rdata(rdata)
    );

    int n_checks = 0;
    int n_fail   = 0;
    int cyc_k    = 0;
    bit finished = 1'b0;

    logic [63:0] exp_q[$];
    logic [63:0] obs_q[$];
    string       tag_q[$];

    task automatic chk(string req, logic [63:0] act, logic [63:0] expv);
        n_checks++;
        if (act !== expv) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, expv);
        end
    endtask

    // one bus cycle each; called just after a falling edge
    task automatic bus_wr(logic [7:0] a, logic [31:0] d);
        cs = 1'b1; we = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        cs = 1'b0; we = 1'b0;
        cyc_k++;
    endtask

    task automatic bus_rd(logic [7:0] a, output logic [31:0] d);
        cs = 1'b1; we = 1'b0; addr = a; wdata = 32'hC3C3_3C3C ^ {24'b0, a};
        #2 d = rdata;
        @(negedge clk);
        cs = 1'b0;
        cyc_k++;
    endtask

    task automatic rd_chk(string req, logic [7:0] a, logic [31:0] expv);
        logic [31:0] d;
        bus_rd(a, d);
        chk(req, {32'b0, d}, {32'b0, expv});
    endtask

    task automatic load_op(logic [127:0] k, logic [63:0] b, logic dec);
        bus_wr(8'h10, k[127:96]);
        bus_wr(8'h11, k[95:64]);
        bus_wr(8'h12, k[63:32]);
        bus_wr(8'h13, k[31:0]);
        bus_wr(8'h20, b[63:32]);
        bus_wr(8'h21, b[31:0]);
        bus_wr(8'h0A, {31'b0, dec});
    endtask

    // poll status; cyc_k counts cycles since the start edge
    task automatic wait_done();
        logic [31:0] d;
        int k_at;
        k_at = cyc_k;
        bus_rd(8'h09, d);
        chk("R6 status low while running", {63'b0, d[0]}, 64'd0);
        while (d[0] == 1'b0 && cyc_k < 60) begin
            k_at = cyc_k;
            bus_rd(8'h09, d);
        end
        chk("R6 R10 latency", 64'(k_at), 64'd12);
    endtask

    task automatic grab_result();
        logic [31:0] hi, lo;
        bus_rd(8'h30, hi);
        bus_rd(8'h31, lo);
        obs_q.push_back({hi, lo});
    endtask

    task automatic run_op(logic [127:0] k, logic [63:0] b, logic dec,
                          logic [63:0] expv, string tag);
        load_op(k, b, dec);
        exp_q.push_back(expv);
        tag_q.push_back(tag);
        bus_wr(8'h08, 32'h1);
        cyc_k = 0;
        wait_done();
        grab_result();
    endtask

    // scoreboard monitor
    initial begin
        forever begin
            @(posedge clk);
            while (obs_q.size() > 0 && exp_q.size() > 0) begin
                logic [63:0] o, e;
                string t;
                o = obs_q.pop_front();
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                chk(t, o, e);
            end
        end
    end

    // test vectors: plaintext, k0, k1, ciphertext
    logic [63:0] v_pt [5];
    logic [63:0] v_k0 [5];
    logic [63:0] v_k1 [5];
    logic [63:0] v_ct [5];

    initial begin
        logic [31:0] d;
        v_pt[0] = 64'h0000000000000000; v_k0[0] = 64'h0; v_k1[0] = 64'h0;
        v_ct[0] = 64'h818665AA0D02DFDA;
        v_pt[1] = 64'hFFFFFFFFFFFFFFFF; v_k0[1] = 64'h0; v_k1[1] = 64'h0;
        v_ct[1] = 64'h604AE6CA03C20ADA;
        v_pt[2] = 64'h0000000000000000; v_k0[2] = 64'hFFFFFFFFFFFFFFFF; v_k1[2] = 64'h0;
        v_ct[2] = 64'h9FB51935FC3DF524;
        v_pt[3] = 64'h0000000000000000; v_k0[3] = 64'h0; v_k1[3] = 64'hFFFFFFFFFFFFFFFF;
        v_ct[3] = 64'h78A54CBE737BB7EF;
        v_pt[4] = 64'h0123456789ABCDEF; v_k0[4] = 64'h0; v_k1[4] = 64'hFEDCBA9876543210;
        v_ct[4] = 64'hAE25AD3CA8FA9CCF;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        rd_chk("R1 status", 8'h09, 32'h0);
        rd_chk("R1 result hi", 8'h30, 32'h0);
        rd_chk("R1 result lo", 8'h31, 32'h0);
        rd_chk("R1 config", 8'h0A, 32'h0);
        rd_chk("R1 key word", 8'h13, 32'h0);
        rd_chk("R1 block word", 8'h20, 32'h0);

        // R3: read-only, unmapped, idle bus
        rd_chk("R3 unmapped", 8'h55, 32'h0);
        rd_chk("R3 control reads 0", 8'h08, 32'h0);
        bus_wr(8'h30, 32'h12345678);
        bus_wr(8'h31, 32'h9ABCDEF0);
        rd_chk("R3 result read-only hi", 8'h30, 32'h0);
        rd_chk("R3 result read-only lo", 8'h31, 32'h0);
        #2 chk("R3 rdata idle", {32'b0, rdata}, 64'd0);

        // R2: register write and readback
        bus_wr(8'h10, 32'h1111_0001);
        bus_wr(8'h11, 32'h2222_0002);
        bus_wr(8'h12, 32'h3333_0003);
        bus_wr(8'h13, 32'h4444_0004);
        bus_wr(8'h20, 32'h5555_0005);
        bus_wr(8'h21, 32'h6666_0006);
        rd_chk("R2 key 0x10", 8'h10, 32'h1111_0001);
        rd_chk("R2 key 0x11", 8'h11, 32'h2222_0002);
        rd_chk("R2 key 0x12", 8'h12, 32'h3333_0003);
        rd_chk("R2 key 0x13", 8'h13, 32'h4444_0004);
        rd_chk("R2 block 0x20", 8'h20, 32'h5555_0005);
        rd_chk("R2 block 0x21", 8'h21, 32'h6666_0006);
        bus_wr(8'h0A, 32'hFFFF_FFFE);
        rd_chk("R2 config keeps bit0 only", 8'h0A, 32'h0);
        bus_wr(8'h0A, 32'h0000_0003);
        rd_chk("R2 config set", 8'h0A, 32'h1);

        // R4 / R5: published vectors, then round trip
        for (int i = 0; i < 5; i++) begin
            run_op({v_k0[i], v_k1[i]}, v_pt[i], 1'b0, v_ct[i], $sformatf("R4 encrypt vector %0d", i));
            run_op({v_k0[i], v_k1[i]}, v_ct[i], 1'b1, v_pt[i], $sformatf("R5 decrypt vector %0d", i));
        end

        // R6: control write with bit0 clear starts nothing
        bus_wr(8'h08, 32'h0000_0002);
        rd_chk("R6 no start on bit0=0", 8'h09, 32'h1);
        rd_chk("R6 no start on bit0=0, second look", 8'h09, 32'h1);
        rd_chk("R6 result untouched", 8'h30, v_pt[4][63:32]);

        // R7 / R8 / R9: writes during a run
        load_op(128'h0, 64'h0, 1'b0);
        exp_q.push_back(v_ct[0]);
        tag_q.push_back("R7 R8 result of run with busy writes");
        bus_wr(8'h08, 32'h1);
        cyc_k = 0;
        rd_chk("R9 old result readable while busy", 8'h30, v_pt[4][63:32]);
        bus_wr(8'h10, 32'hDEAD_BEEF);
        bus_wr(8'h21, 32'hFFFF_FFFF);
        bus_wr(8'h0A, 32'h1);
        bus_wr(8'h08, 32'h1);
        wait_done();
        grab_result();
        rd_chk("R8 key unchanged", 8'h10, 32'h0);
        rd_chk("R8 block unchanged", 8'h21, 32'h0);
        rd_chk("R8 config unchanged", 8'h0A, 32'h0);
        rd_chk("R7 no second run", 8'h09, 32'h1);

        repeat (4) @(negedge clk);
        chk("R4 scoreboard drained", 64'(exp_q.size()), 64'd0);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule